// File: doc/BRIEF.md
# DMA Interrupt Status Register Bank

This block is the register front end of an eight-channel DMA controller. It holds one raw terminal-count flag and one raw error flag per channel. The transfer engine raises these flags with single-cycle set pulses, and software lowers them with write-one-to-clear writes. Each channel's own configuration word supplies its two interrupt mask bits, so there is no separate mask register. Software can read the flags raw, masked per kind, or masked and merged. The block drives one level interrupt line that is high while any masked flag is set.

The same word-addressed bus also reaches the rest of the block's state:
- five storage words for each channel in a window starting at byte offset 0x100;
- a summary of which channels are enabled;
- a global configuration word and a synchronisation word;
- eight read-only identification bytes at the top of the 4 KiB space.

Reads are combinational from the address. Writes take effect on the rising clock edge. The channel count is a parameter: eight by default, and two for the small build.

Top module: `dma_int_regs`

## Requirements
- R1: After reset every raw flag, every channel word and both global words read zero, and the interrupt output is low.
- R2: A set pulse on bit n of the terminal-count or error set input raises raw flag n one clock later. Raw terminal-count flags read at byte offset 0x014 and raw error flags read at 0x018, with bit n for channel n.
- R3: Channel n's terminal-count mask is bit 15 of its configuration word, and its error mask is bit 14. Offset 0x004 reads the masked terminal-count flags, 0x00C reads the masked error flags, and 0x000 reads the OR of the two masked views.
- R4: A write to 0x008 clears each raw terminal-count flag whose written data bit is 1. A write to 0x010 does the same for the raw error flags. Flags whose data bit is 0 keep their value.
- R5: When a set pulse and a clearing write hit the same flag in the same cycle, the flag ends up set.
- R6: The interrupt output is high exactly while at least one masked terminal-count or masked error flag is set. It follows changes to both the flags and the mask bits.
- R7: Offset 0x01C reads a vector whose bit n is bit 0 (the enable bit) of channel n's configuration word.
- R8: Offset 0x030 is a 32-bit global configuration word and offset 0x034 is a 32-bit sync word. Both read back what was last written.
- R9: Channel n's words sit at 0x100 + 32·n in the order source, destination, next pointer, control, configuration. Each reads back its last write. Slots 5 to 7 of a channel read zero.
- R10: A channel number at or above the built channel count reads zero in every slot, and writes to it are ignored.
- R11: Offsets 0xFE0 to 0xFFC each return one identification byte: 0x80, 0x10, 0x04, 0x0A, 0x0D, 0xF0, 0x05, 0xB1. The first byte is 0x81 in a two-channel build. Writes there change nothing.
- R12: Offsets 0x020 to 0x02C and every other undecoded offset read zero, and writes to them change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe for the addressed word |
| bus_addr | input | 12 | Byte address (bits 1:0 ignored) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| tc_set | input | NUM_CH | Terminal-count set pulses from the engine |
| err_set | input | NUM_CH | Error set pulses from the engine |
| irq | output | 1 | Combined masked interrupt |

## Verification
The bench targets the collision between a set pulse and a clearing write to the same flag. A design that lets the clear win loses a terminal-count event without any trace.

It also checks that masking is done at read time, not when the flag is set. Clearing a mask bit must drop the interrupt while the raw flag stays visible. Setting the mask bit again later must expose the flag that is already pending. A design that latched masks at set time would fail both checks.

A second, two-channel instance confirms that channels beyond the built count read zero and do not wrap onto real channels, and that its first identification byte changes. Writes to the software-request words and the identification bytes are followed by read-backs of the neighbouring global state.

// File: rtl/dma_regs_pkg.sv
package dma_regs_pkg;

  // Global word indices (byte offset / 4) within 0x000-0x0FF
  localparam logic [5:0] W_STAT     = 6'd0;
  localparam logic [5:0] W_TC_VIEW  = 6'd1;
  localparam logic [5:0] W_TC_CLR   = 6'd2;
  localparam logic [5:0] W_ERR_VIEW = 6'd3;
  localparam logic [5:0] W_ERR_CLR  = 6'd4;
  localparam logic [5:0] W_TC_RAW   = 6'd5;
  localparam logic [5:0] W_ERR_RAW  = 6'd6;
  localparam logic [5:0] W_EN_SUM   = 6'd7;
  localparam logic [5:0] W_GCFG     = 6'd12;
  localparam logic [5:0] W_SYNC     = 6'd13;

  // Per-channel slots, order fixed by the window layout
  typedef enum logic [2:0] {
    SLOT_SRC  = 3'd0,
    SLOT_DST  = 3'd1,
    SLOT_NEXT = 3'd2,
    SLOT_CTRL = 3'd3,
    SLOT_CONF = 3'd4
  } slot_e;
  localparam int NUM_SLOTS = 5;

  // Bits of a channel configuration word used here
  localparam int CONF_EN_BIT  = 0;
  localparam int CONF_ERM_BIT = 14;
  localparam int CONF_TCM_BIT = 15;

  // Identification byte for word idx of the top 32-byte block
  function automatic logic [7:0] id_byte(input logic [2:0] idx, input bit small_build);
    case (idx)
      3'd0:    id_byte = small_build ? 8'h81 : 8'h80;
      3'd1:    id_byte = 8'h10;
      3'd2:    id_byte = 8'h04;
      3'd3:    id_byte = 8'h0A;
      3'd4:    id_byte = 8'h0D;
      3'd5:    id_byte = 8'hF0;
      3'd6:    id_byte = 8'h05;
      default: id_byte = 8'hB1;
    endcase
  endfunction

  // Next raw flag vector: clear first, set wins
  function automatic logic [7:0] flag_next(input logic [7:0] cur, input logic [7:0] drop,
                                           input logic [7:0] raise);
    flag_next = (cur & ~drop) | raise;
  endfunction

endpackage

// File: rtl/dma_chan_file.sv
module dma_chan_file
  import dma_regs_pkg::*;
#(
  parameter int NUM_CH = 8,
  parameter int DW     = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              in_window,
  input  logic [2:0]        chan_sel,
  input  logic [2:0]        slot_sel,
  input  logic [DW-1:0]     wdata,
  output logic [DW-1:0]     rd_word,
  output logic [NUM_CH-1:0] conf_en,
  output logic [NUM_CH-1:0] tc_mask,
  output logic [NUM_CH-1:0] err_mask
);
  localparam int CH_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;

  logic [DW-1:0] bank [NUM_CH][NUM_SLOTS];

  // Decode events
  logic chan_hit, slot_hit, store_ev;
  assign chan_hit = ({29'd0, chan_sel} < NUM_CH);
  assign slot_hit = ({29'd0, slot_sel} < NUM_SLOTS);
  assign store_ev = wr_en && in_window && chan_hit && slot_hit;

  always_ff @(posedge clk) begin
    for (int c = 0; c < NUM_CH; c++) begin
      for (int s = 0; s < NUM_SLOTS; s++) begin
        if (!rst_n)
          bank[c][s] <= '0;
        else if (store_ev && chan_sel == 3'(c) && slot_sel == 3'(s))
          bank[c][s] <= wdata;
      end
    end
  end

  always_comb begin
    rd_word = '0;
    if (chan_hit && slot_hit)
      rd_word = bank[chan_sel[CH_W-1:0]][slot_sel];
  end

  for (genvar g = 0; g < NUM_CH; g++) begin : g_mask
    assign conf_en[g]  = bank[g][SLOT_CONF][CONF_EN_BIT];
    assign tc_mask[g]  = bank[g][SLOT_CONF][CONF_TCM_BIT];
    assign err_mask[g] = bank[g][SLOT_CONF][CONF_ERM_BIT];
  end

  // R9: configuration derived bits only move on a write
  assert_conf_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> (conf_en == $past(conf_en) && tc_mask == $past(tc_mask)));

endmodule

// File: rtl/dma_irq_state.sv
module dma_irq_state
  import dma_regs_pkg::*;
#(
  parameter int NUM_CH = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] tc_set,
  input  logic [NUM_CH-1:0] err_set,
  input  logic              tc_clr_we,
  input  logic              err_clr_we,
  input  logic [NUM_CH-1:0] clr_bits,
  input  logic [NUM_CH-1:0] tc_mask,
  input  logic [NUM_CH-1:0] err_mask,
  output logic [NUM_CH-1:0] raw_tc,
  output logic [NUM_CH-1:0] raw_err,
  output logic [NUM_CH-1:0] tc_view,
  output logic [NUM_CH-1:0] err_view,
  output logic              irq
);
  logic [NUM_CH-1:0] tc_drop, err_drop;
  logic [7:0]        tc_nx8, err_nx8;

  assign tc_drop  = tc_clr_we  ? clr_bits : '0;
  assign err_drop = err_clr_we ? clr_bits : '0;
  assign tc_nx8   = flag_next(8'(raw_tc),  8'(tc_drop),  8'(tc_set));
  assign err_nx8  = flag_next(8'(raw_err), 8'(err_drop), 8'(err_set));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      raw_tc  <= '0;
      raw_err <= '0;
    end else begin
      raw_tc  <= tc_nx8[NUM_CH-1:0];
      raw_err <= err_nx8[NUM_CH-1:0];
    end
  end

  logic [7:0] unused_hi;
  assign unused_hi = {tc_nx8 ^ err_nx8};

  assign tc_view  = raw_tc & tc_mask;
  assign err_view = raw_err & err_mask;
  assign irq      = |{tc_view, err_view};

  assert_set_lands_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (|err_set) |=> ((raw_err & $past(err_set)) == $past(err_set)));

  assert_set_beats_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (tc_clr_we && |(clr_bits & tc_set)) |=>
      ((raw_tc & $past(clr_bits & tc_set)) == $past(clr_bits & tc_set)));

  assert_clear_drops_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (err_clr_we && err_set == '0) |=> ((raw_err & $past(clr_bits)) == '0));

  assert_raw_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!tc_clr_we && tc_set == '0) |=> (raw_tc == $past(raw_tc)));

endmodule

// File: rtl/dma_int_regs.sv
module dma_int_regs
  import dma_regs_pkg::*;
#(
  parameter int NUM_CH = 8,
  parameter int AW     = 12,
  parameter int DW     = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [AW-1:0]     bus_addr,
  input  logic [DW-1:0]     bus_wdata,
  output logic [DW-1:0]     bus_rdata,
  input  logic [NUM_CH-1:0] tc_set,
  input  logic [NUM_CH-1:0] err_set,
  output logic              irq
);
  localparam bit SMALL = (NUM_CH == 2);

  // Address decode
  logic       in_global, in_window, in_id;
  logic [5:0] gword;
  logic [2:0] chan_sel, slot_sel;
  logic [1:0] unused_lsb;
  assign in_global  = (bus_addr[AW-1:8] == '0);
  assign in_window  = (bus_addr[AW-1:8] == (AW-8)'(1));
  assign in_id      = (bus_addr[AW-1:5] == '1);
  assign gword      = bus_addr[7:2];
  assign chan_sel   = bus_addr[7:5];
  assign slot_sel   = bus_addr[4:2];
  assign unused_lsb = bus_addr[1:0];

  // Named write events
  logic tc_clr_we, err_clr_we, gcfg_we, sync_we;
  assign tc_clr_we  = bus_wr && in_global && gword == W_TC_CLR;
  assign err_clr_we = bus_wr && in_global && gword == W_ERR_CLR;
  assign gcfg_we    = bus_wr && in_global && gword == W_GCFG;
  assign sync_we    = bus_wr && in_global && gword == W_SYNC;

  logic [DW-1:0]     chan_rd;
  logic [NUM_CH-1:0] conf_en, tc_mask, err_mask;
  logic [NUM_CH-1:0] raw_tc, raw_err, tc_view, err_view;
  logic [DW-1:0]     gcfg_q, sync_q;

  dma_chan_file #(.NUM_CH(NUM_CH), .DW(DW)) u_chan (
    .clk(clk), .rst_n(rst_n), .wr_en(bus_wr), .in_window(in_window),
    .chan_sel(chan_sel), .slot_sel(slot_sel), .wdata(bus_wdata),
    .rd_word(chan_rd), .conf_en(conf_en), .tc_mask(tc_mask), .err_mask(err_mask)
  );

  dma_irq_state #(.NUM_CH(NUM_CH)) u_irq (
    .clk(clk), .rst_n(rst_n), .tc_set(tc_set), .err_set(err_set),
    .tc_clr_we(tc_clr_we), .err_clr_we(err_clr_we), .clr_bits(bus_wdata[NUM_CH-1:0]),
    .tc_mask(tc_mask), .err_mask(err_mask), .raw_tc(raw_tc), .raw_err(raw_err),
    .tc_view(tc_view), .err_view(err_view), .irq(irq)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gcfg_q <= '0;
      sync_q <= '0;
    end else begin
      if (gcfg_we) gcfg_q <= bus_wdata;
      if (sync_we) sync_q <= bus_wdata;
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (in_id) begin
      bus_rdata = DW'(id_byte(bus_addr[4:2], SMALL));
    end else if (in_window) begin
      bus_rdata = chan_rd;
    end else if (in_global) begin
      case (gword)
        W_STAT:     bus_rdata = DW'(tc_view | err_view);
        W_TC_VIEW:  bus_rdata = DW'(tc_view);
        W_ERR_VIEW: bus_rdata = DW'(err_view);
        W_TC_RAW:   bus_rdata = DW'(raw_tc);
        W_ERR_RAW:  bus_rdata = DW'(raw_err);
        W_EN_SUM:   bus_rdata = DW'(conf_en);
        W_GCFG:     bus_rdata = gcfg_q;
        W_SYNC:     bus_rdata = sync_q;
        default:    bus_rdata = '0;
      endcase
    end
  end

  assert_gcfg_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !gcfg_we |=> (gcfg_q == $past(gcfg_q)));

  assert_irq_needs_mask_R6: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (|{tc_mask, err_mask}));

  assert_irq_off_in_reset_R1: assert property (@(posedge clk)
    !rst_n |=> !irq);

endmodule

// File: tb/sim_dma_int_regs.sv
module sim_dma_int_regs;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        bus_wr = 0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [7:0]  tc_set = '0, err_set = '0;
  logic [31:0] rd0, rd1;
  logic        irq0, irq1;
  int errors = 0, checks = 0;
  bit done = 0;

  always #10 clk = ~clk;  // 50 MHz

  dma_int_regs #(.NUM_CH(8)) u0 (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(rd0), .tc_set(tc_set), .err_set(err_set), .irq(irq0));

  dma_int_regs #(.NUM_CH(2)) u1 (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(rd1), .tc_set(tc_set[1:0]), .err_set(err_set[1:0]),
    .irq(irq1));

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk); bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 0;
  endtask

  task automatic rd(input logic [11:0] a);
    @(negedge clk); bus_addr = a; #2;
  endtask

  task automatic pulse(input logic [7:0] t, input logic [7:0] e);
    @(negedge clk); tc_set = t; err_set = e;
    @(negedge clk); tc_set = 0; err_set = 0;
  endtask

  task automatic t_reset;
    rd(12'h000); check("R1 status", rd0, 0); check("R1 irq", {31'd0, irq0}, 0);
    rd(12'h014); check("R1 raw tc", rd0, 0);
    rd(12'h030); check("R1 gcfg", rd0, 0);
    rd(12'h110); check("R1 chan0 conf", rd0, 0);
  endtask

  task automatic t_window;
    for (int s = 0; s < 5; s++) wr(12'h160 + 12'(4*s), 32'hC0DE_0000 + 32'(s) + (s == 4 ? 32'h0C00 : 0));
    for (int s = 0; s < 4; s++) begin
      rd(12'h160 + 12'(4*s)); check("R9 chan3 slot", rd0, 32'hC0DE_0000 + 32'(s));
    end
    rd(12'h170); check("R9 chan3 conf", rd0, 32'hC0DE_0C04);
    wr(12'h1F0, 32'h0000_0002);
    rd(12'h1F0); check("R9 chan7 conf", rd0, 32'h2);
    wr(12'h174, 32'hFFFF_FFFF);
    rd(12'h174); check("R9 slot5 zero", rd0, 0);
  endtask

  task automatic t_masks;
    wr(12'h110, 32'h0000_8000);
    wr(12'h130, 32'h0000_4000);
    pulse(8'h03, 8'h03);
    rd(12'h014); check("R2 raw tc", rd0, 32'h3);
    rd(12'h018); check("R2 raw err", rd0, 32'h3);
    rd(12'h004); check("R3 masked tc", rd0, 32'h1);
    rd(12'h00C); check("R3 masked err", rd0, 32'h2);
    rd(12'h000); check("R3 combined", rd0, 32'h3);
    check("R6 irq high", {31'd0, irq0}, 1);
    wr(12'h110, 0); wr(12'h130, 0);
    rd(12'h000); check("R3 unmasked view", rd0, 0);
    check("R6 irq follows mask", {31'd0, irq0}, 0);
    rd(12'h014); check("R3 raw kept", rd0, 32'h3);
    wr(12'h110, 32'h0000_8000);
    check("R6 remask pending", {31'd0, irq0}, 1);
    wr(12'h110, 0);
  endtask

  task automatic t_w1c;
    wr(12'h008, 32'h1);
    rd(12'h014); check("R4 tc clear bit0", rd0, 32'h2);
    rd(12'h018); check("R4 err untouched", rd0, 32'h3);
    wr(12'h010, 32'h3);
    rd(12'h018); check("R4 err cleared", rd0, 0);
    wr(12'h008, 32'hFF);
    rd(12'h014); check("R4 tc cleared", rd0, 0);
  endtask

  task automatic t_set_wins;
    @(negedge clk); bus_wr = 1; bus_addr = 12'h008; bus_wdata = 32'h5; tc_set = 8'h05;
    @(negedge clk); bus_wr = 0; tc_set = 0;
    rd(12'h014); check("R5 set wins", rd0, 32'h5);
    wr(12'h008, 32'h5);
    rd(12'h014); check("R5 cleared after", rd0, 0);
    wr(12'h150, 32'h0000_8000);
    pulse(8'h04, 0);
    check("R6 irq chan2", {31'd0, irq0}, 1);
    wr(12'h008, 32'h4);
    check("R6 irq drop", {31'd0, irq0}, 0);
  endtask

  task automatic t_enable;
    wr(12'h1B0, 32'h1);
    wr(12'h150, 32'h8001);
    rd(12'h01C); check("R7 enable summary", rd0, 32'h24);
    check("R10 small summary", rd1, 0);
  endtask

  task automatic t_global;
    wr(12'h030, 32'hDEAD_BEEF); wr(12'h034, 32'h1234_5678);
    rd(12'h030); check("R8 gcfg", rd0, 32'hDEAD_BEEF);
    rd(12'h034); check("R8 sync", rd0, 32'h1234_5678);
  endtask

  task automatic t_id;
    logic [7:0] exp [8] = '{8'h80, 8'h10, 8'h04, 8'h0A, 8'h0D, 8'hF0, 8'h05, 8'hB1};
    wr(12'hFE0, 32'h55);
    for (int i = 0; i < 8; i++) begin
      rd(12'hFE0 + 12'(4*i)); check("R11 id byte", rd0, {24'd0, exp[i]});
    end
    rd(12'hFE0); check("R11 small id", rd1, 32'h81);
  endtask

  task automatic t_reserved;
    for (int w = 8; w < 12; w++) wr(12'(4*w), 32'hFFFF_FFFF);
    wr(12'h038, 32'hFFFF_FFFF);
    wr(12'h200, 32'hFFFF_FFFF);
    for (int w = 8; w < 12; w++) begin
      rd(12'(4*w)); check("R12 soft req zero", rd0, 0);
    end
    rd(12'h038); check("R12 undecoded zero", rd0, 0);
    rd(12'h200); check("R12 gap zero", rd0, 0);
    rd(12'h030); check("R12 gcfg unchanged", rd0, 32'hDEAD_BEEF);
    rd(12'h014); check("R12 raw unchanged", rd0, 0);
  endtask

  task automatic t_small;
    rd(12'h160); check("R10 absent chan read", rd1, 0);
    check("R10 big build keeps", rd0, 32'hC0DE_0000);
    wr(12'h140, 32'h77);
    rd(12'h100); check("R10 no wrap to chan0", rd1, 0);
    rd(12'h110); check("R10 chan0 conf intact", rd1, 0);
  endtask

  initial begin
    #(20 * 100000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_window();
    t_masks();
    t_w1c();
    t_set_wins();
    t_enable();
    t_global();
    t_id();
    t_reserved();
    t_small();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule